// File: doc/BRIEF.md
# Pulse-Swallow Programmable Frequency Divider

This block divides a fast input clock by a programmable integer ratio of 8·N1 + N2. It combines a dual-modulus prescaler that divides by 9 or by 8, a 5-bit main down counter and a 3-bit swallow down counter. While the swallow counter is non-zero the prescaler uses its wider modulus. Once the swallow counter reaches zero it parks there and the prescaler drops to the narrower modulus. When the main counter expires, one reload loads both counters again and a new output period starts. Everything runs synchronously in the input clock domain, and the prescaler is an internal counter.

The divided output is the stream of reload pulses: one pulse, one input clock wide, in each output period. The modulus-select state is brought out for observation. The divide word is taken only at a reload, so a period in progress is never cut short. Asserting the synchronous reset forces a reload at once, which lets software apply a new ratio in the middle of a period. An illegal word does not change the ratio. Instead the block raises an error flag and keeps the last legal setting.

In a frequency synthesiser, the ratios 52 to 148 in steps of 8 take every band centre of a wideband front end down to one common comparison frequency.

Top module: `pswallow_div`

## Requirements
- R1: For every legal word (N1 = div_word[4:0], N2 = div_word[7:5], N1 > N2), rising `div_out` pulses in steady operation are exactly 8·N1 + N2 input clocks apart.
- R2: `div_out` is never high for two consecutive clock cycles.
- R3: Each output period begins with `sel` low for exactly 9·N2 input clocks and keeps `sel` high for the rest. With N2 = 0, `sel` stays high for the whole period. `sel` only falls together with a reload.
- R4: The divide word is sampled only at a reload. A word changed during a period leaves that period's length unchanged and sets the length of the next period.
- R5: A clock edge with `rst` high reloads both counters from the word. No `div_out` pulse appears while `rst` is high. The first pulse comes exactly 8·N1 + N2 clocks after the last edge at which `rst` was high.
- R6: A word with N1 ≤ N2 (which includes N1 = 0) that is seen at a reload sets `err` high and keeps the previous legal ratio. `err` changes only at a reload or under reset, and it clears at the first reload that sees a legal word.
- R7: An illegal word presented under `rst` selects the default ratio 52 (N1 = 6, N2 = 4) and sets `err` high.
- R8: While `rst` is high with a legal word, `div_out` is low, `err` is low, and `sel` equals (N2 == 0).
- R9: The band ratios 52, 60, …, 148 are each produced with N2 = 4 and N1 = 6 to 18.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst | input | 1 | Synchronous active-high reset that forces an immediate reload |
| div_word | input | 8 | Divide word: bits 4:0 main count N1, bits 7:5 swallow count N2 |
| div_out | output | 1 | Divided output, one-clock pulse per output period |
| sel | output | 1 | Prescaler modulus select, high while dividing by 8 |
| err | output | 1 | High after a reload that rejected an illegal word |

## Verification
The bench builds the block with its default parameters: a base modulus of 8, a 5-bit main counter and a 3-bit swallow counter. This word space is small enough to sweep every legal (N1, N2) pair, all 220 of them. For each pair the bench measures the first period after reset, a steady period, and the number of clocks spent at the wide modulus, and compares them against 8·N1 + N2 and 9·N2. Directed runs then change the word in the middle of a period, present words that break N1 > N2 (including N1 = 0) both at a reload and under reset, and step through the thirteen band ratios.

// File: rtl/pswallow_pkg.sv
package pswallow_pkg;

  // Prescaler modulus choice: WIDE divides by base+1, BASE divides by base.
  typedef enum logic {
    MOD_WIDE = 1'b0,
    MOD_BASE = 1'b1
  } pw_mod_e;

  // A setting is usable only when the main count exceeds the swallow count.
  function automatic bit pw_legal(input int unsigned main_cnt,
                                  input int unsigned swl_cnt);
    return main_cnt > swl_cnt;
  endfunction

endpackage

// File: rtl/pswallow_prescaler.sv
module pswallow_prescaler
  import pswallow_pkg::*;
#(
  parameter int BASE = 8,
  localparam int PW = $clog2(BASE + 1)
) (
  input  logic    clk,
  input  logic    rst,
  input  pw_mod_e mod_sel,
  output logic    tick
);

  logic [PW-1:0] pc_q;
  logic [PW-1:0] limit;

  // Last count value of the current prescaler cycle.
  assign limit = (mod_sel == MOD_BASE) ? PW'(BASE - 1) : PW'(BASE);
  assign tick  = (pc_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (tick) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end

endmodule

// File: rtl/pswallow_downcnt.sv
module pswallow_downcnt #(
  parameter int W    = 5,
  parameter bit PARK = 1'b0
) (
  input  logic         clk,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         at_one
);

  logic [W-1:0] cnt_q;
  logic         step;

  generate
    if (PARK) begin : g_park
      // Holds at zero until the next load.
      assign step = dec && (cnt_q != '0);
    end else begin : g_free
      assign step = dec;
    end
  endgenerate

  assign at_one = (cnt_q == W'(1));

  always_ff @(posedge clk) begin
    if (load) begin
      cnt_q <= load_val;
    end else if (step) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/pswallow_cfg.sv
module pswallow_cfg
  import pswallow_pkg::*;
#(
  parameter int MAIN_W   = 5,
  parameter int SWL_W    = 3,
  parameter int DEF_MAIN = 6,
  parameter int DEF_SWL  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reload,
  input  logic [MAIN_W-1:0] word_main,
  input  logic [SWL_W-1:0]  word_swl,
  output logic [MAIN_W-1:0] ld_main,
  output logic [SWL_W-1:0]  ld_swl,
  output logic              err
);

  logic [MAIN_W-1:0] keep_main_q;
  logic [SWL_W-1:0]  keep_swl_q;
  logic              err_q;
  logic              word_ok;

  assign word_ok = pw_legal(int'(unsigned'(word_main)), int'(unsigned'(word_swl)));

  // Values loaded into the counters at this edge if a load happens.
  always_comb begin
    if (word_ok) begin
      ld_main = word_main;
      ld_swl  = word_swl;
    end else if (rst) begin
      ld_main = MAIN_W'(DEF_MAIN);
      ld_swl  = SWL_W'(DEF_SWL);
    end else begin
      ld_main = keep_main_q;
      ld_swl  = keep_swl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || reload) begin
      keep_main_q <= ld_main;
      keep_swl_q  <= ld_swl;
      err_q       <= !word_ok;
    end
  end

  assign err = err_q;

endmodule

// File: rtl/pswallow_div.sv
module pswallow_div
  import pswallow_pkg::*;
#(
  parameter int BASE     = 8,
  parameter int MAIN_W   = 5,
  parameter int SWL_W    = 3,
  parameter int DEF_MAIN = 6,
  parameter int DEF_SWL  = 4,
  localparam int WORD_W  = MAIN_W + SWL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] div_word,
  output logic              div_out,
  output logic              sel,
  output logic              err
);

  logic              tick;
  logic              main_one;
  logic              swl_one;
  logic              reload;
  logic              load;
  logic [MAIN_W-1:0] ld_main;
  logic [SWL_W-1:0]  ld_swl;
  logic              sel_q;
  logic              out_q;

  assign reload = tick && main_one;
  assign load   = rst || reload;

  pswallow_cfg #(
    .MAIN_W   (MAIN_W),
    .SWL_W    (SWL_W),
    .DEF_MAIN (DEF_MAIN),
    .DEF_SWL  (DEF_SWL)
  ) u_cfg (
    .clk       (clk),
    .rst       (rst),
    .reload    (reload),
    .word_main (div_word[MAIN_W-1:0]),
    .word_swl  (div_word[WORD_W-1:MAIN_W]),
    .ld_main   (ld_main),
    .ld_swl    (ld_swl),
    .err       (err)
  );

  pswallow_prescaler #(
    .BASE (BASE)
  ) u_pre (
    .clk     (clk),
    .rst     (rst),
    .mod_sel (pw_mod_e'(sel_q)),
    .tick    (tick)
  );

  pswallow_downcnt #(
    .W    (MAIN_W),
    .PARK (1'b0)
  ) u_main (
    .clk      (clk),
    .load     (load),
    .load_val (ld_main),
    .dec      (tick),
    .at_one   (main_one)
  );

  pswallow_downcnt #(
    .W    (SWL_W),
    .PARK (1'b1)
  ) u_swl (
    .clk      (clk),
    .load     (load),
    .load_val (ld_swl),
    .dec      (tick),
    .at_one   (swl_one)
  );

  // Registered modulus select: high once the swallow counter has parked.
  always_ff @(posedge clk) begin
    if (load) begin
      sel_q <= (ld_swl == '0);
    end else if (tick && swl_one) begin
      sel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
    end else begin
      out_q <= reload;
    end
  end

  assign div_out = out_q;
  assign sel     = sel_q;

endmodule

// File: rtl/pswallow_div_chk.sv
module pswallow_div_chk #(
  parameter int BASE = 8
) (
  input logic clk,
  input logic rst,
  input logic div_out,
  input logic sel,
  input logic err
);

  logic [15:0] gap_q;
  logic        rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || div_out) begin
      gap_q <= '0;
    end else if (gap_q != 16'hFFFF) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R5: nothing leaves the block in the cycle after a reset edge.
  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      p_quiet_in_reset_r5: assert (div_out == 1'b0);
    end
  end

  p_one_cycle_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    div_out |=> !div_out);

  p_sel_falls_on_reload_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(sel) |-> (div_out || $past(rst)));

  p_err_moves_on_reload_r6: assert property (@(posedge clk) disable iff (rst)
    !$stable(err) |-> (div_out || $past(rst)));

  p_gap_floor_r1: assert property (@(posedge clk) disable iff (rst)
    div_out |-> (gap_q >= 16'(BASE - 1)));

endmodule

bind pswallow_div pswallow_div_chk #(.BASE(BASE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .div_out (div_out),
  .sel     (sel),
  .err     (err)
);

// File: tb/pswallow_div_tb.sv
module pswallow_div_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] word = 8'h86;
  logic       div_out;
  logic       sel;
  logic       err;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  pswallow_div u_dut (
    .clk      (clk),
    .rst      (rst),
    .div_word (word),
    .div_out  (div_out),
    .sel      (sel),
    .err      (err)
  );

  function automatic logic [7:0] mk(input int n1, input int n2);
    return {3'(n2), 5'(n1)};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Hold rst for two edges with word w; return at the negedge after the last rst edge.
  task automatic reset_with(input logic [7:0] w);
    @(negedge clk);
    word = w;
    rst  = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // Counts samples until the next pulse, and sel-low samples from the current one.
  task automatic measure(output int n, output int low);
    n = 0;
    low = 0;
    do begin
      if (!sel) low++;
      @(negedge clk);
      n++;
    end while (!div_out && n < 4000);
  endtask

  initial begin
    int n;
    int low;
    // Sweep of every legal pair: R1, R3, R5, R8, R2
    for (int n1 = 1; n1 < 32; n1++) begin
      for (int n2 = 0; n2 < 8 && n2 < n1; n2++) begin
        reset_with(mk(n1, n2));
        chk(div_out == 1'b0, "R8 div_out in reset", int'(div_out), 0);
        chk(err == 1'b0, "R8 err in reset", int'(err), 0);
        chk(sel == (n2 == 0), "R8 sel in reset", int'(sel), int'(n2 == 0));
        rst = 1'b0;
        measure(n, low);
        chk(n == 8 * n1 + n2, "R5 first period", n, 8 * n1 + n2);
        chk(low == 9 * n2, "R3 wide-modulus clocks", low, 9 * n2);
        measure(n, low);
        chk(n == 8 * n1 + n2, "R1 steady period", n, 8 * n1 + n2);
        chk(low == 9 * n2, "R3 wide-modulus clocks", low, 9 * n2);
        @(negedge clk);
        chk(div_out == 1'b0, "R2 pulse width", int'(div_out), 0);
      end
    end

    // R9: band ratios with N2 = 4
    for (int b = 0; b < 13; b++) begin
      reset_with(mk(6 + b, 4));
      rst = 1'b0;
      measure(n, low);
      measure(n, low);
      chk(n == 52 + 8 * b, "R9 band ratio", n, 52 + 8 * b);
    end

    // R4: word change inside a period
    reset_with(mk(6, 4));
    rst  = 1'b0;
    word = mk(10, 2);
    measure(n, low);
    chk(n == 52, "R4 current period kept", n, 52);
    measure(n, low);
    chk(n == 82, "R4 new word next period", n, 82);

    // R6: illegal words at a reload
    reset_with(mk(6, 4));
    rst = 1'b0;
    measure(n, low);
    chk(err == 1'b0, "R6 err low for legal", int'(err), 0);
    word = mk(3, 5);
    measure(n, low);
    chk(n == 52, "R6 period before reject", n, 52);
    chk(err == 1'b1, "R6 err raised", int'(err), 1);
    word = mk(0, 0);
    measure(n, low);
    chk(n == 52, "R6 ratio kept", n, 52);
    chk(err == 1'b1, "R6 err for N1=0", int'(err), 1);
    word = mk(10, 2);
    measure(n, low);
    chk(n == 52, "R6 ratio kept", n, 52);
    chk(err == 1'b0, "R6 err cleared", int'(err), 0);
    measure(n, low);
    chk(n == 82, "R6 legal word applied", n, 82);

    // R7: illegal word under reset
    reset_with(mk(0, 2));
    chk(err == 1'b1, "R7 err in reset", int'(err), 1);
    rst = 1'b0;
    measure(n, low);
    chk(n == 52, "R7 default ratio", n, 52);
    chk(low == 36, "R7 default swallow", low, 36);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule